// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

The block manages twelve chip pins. Each pin can serve as a general-purpose input, as a general-purpose output, or as a line of a dedicated serial peripheral. It can also be left disconnected. Software selects the use of each pin through two 24-bit configuration registers, a mode register and a direction register. The pin's 2-bit mode is formed as {direction bit, mode bit}. A third 24-bit register carries the data. Writing it sets the levels of output pins. Reading it returns the levels of input pins.

All access uses a small synchronous register bus. Writes take effect at the clock edge on which `we_i` is high. Read data is a combinational function of the address and the current state. Pad inputs cross into the clock domain through a two-flop synchroniser before software can read them. The peripheral's own path bypasses that synchroniser.

Two pin positions, 2 and 5, have no pin behind them. Their configuration bits are hard-wired to zero. A separate synchronous software-reset input returns every pin to the disconnected state and leaves the data register alone.

Top module: `gpio_mux_port`

## Requirements
- R1: After the asynchronous reset `rst_ni`, the mode and direction registers read zero, and every `pad_oe_o` bit is low.
- R2: In all three registers, bits 23..12 read as zero and ignore writes.
- R3: Bit positions 2 and 5 always read zero in all three registers. Writes to those positions have no effect.
- R4: A pin's mode is {direction bit, mode bit}: 00 disconnected, 01 GPIO input, 10 GPIO output, 11 peripheral. In GPIO output mode `pad_oe_o` is high. In GPIO input mode it is low.
- R5: In GPIO output mode, `pad_out_o[i]` equals bit i last written to the data register. That bit also reads back from the data register.
- R6: In GPIO input mode, data register bit i returns `pad_in_i[i]` delayed by two clock edges.
- R7: In peripheral mode, `pad_out_o[i]` = `per_out_i[i]`, `pad_oe_o[i]` = `per_oe_i[i]` and `per_in_o[i]` = `pad_in_i[i]`, all combinationally.
- R8: In any mode other than peripheral, `per_in_o[i]` is 0. In disconnected mode, `pad_oe_o[i]` and `pad_out_o[i]` are 0.
- R9: When `soft_rst_i` is high at a clock edge, the mode and direction registers clear. This takes priority over a write in the same cycle. The data register keeps its contents.
- R10: The mode register is at address 0x1F, the direction register at 0x1E and the data register at 0x1D. Any other address reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| soft_rst_i | input | 1 | Synchronous software reset of configuration |
| addr_i | input | 6 | Register offset |
| we_i | input | 1 | Write enable |
| wdata_i | input | 24 | Write data |
| rdata_o | output | 24 | Read data |
| pad_in_i | input | 12 | Pad input levels |
| pad_out_o | output | 12 | Pad output levels |
| pad_oe_o | output | 12 | Pad output enables |
| per_out_i | input | 12 | Peripheral output per pin |
| per_oe_i | input | 12 | Peripheral output enable per pin |
| per_in_o | output | 12 | Pad level routed to peripheral |

## Verification
The bench builds the block with its default parameters: twelve pins, 24-bit registers, a two-stage synchroniser and an implemented-pin mask that leaves positions 2 and 5 empty. With twelve pins, random register values reach all four modes on many pins at once. The mask makes the empty positions and the dead upper bits visible on every read. The two-stage depth keeps the input lag short enough that directed tests can probe the exact edge at which a pin change becomes visible.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  typedef enum logic [1:0] {
    PM_OFF = 2'b00,
    PM_IN  = 2'b01,
    PM_OUT = 2'b10,
    PM_PER = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs #(
  parameter int              NUM_PINS  = 12,
  parameter int              REG_W     = 24,
  parameter int              ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h1F,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 6'h1E,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 6'h1D,
  parameter logic [NUM_PINS-1:0] IMPL_MASK = 12'hFDB
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] pin_rd_i,
  output logic [NUM_PINS-1:0] ctrl_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] data_o
);
  localparam int PAD_W = REG_W - NUM_PINS;

  logic [NUM_PINS-1:0] ctrl_q, dir_q, data_q, wr_val;
  logic                wr_ctrl, wr_dir, wr_data;
  logic                unused_wdata;

  assign wr_val       = wdata_i[NUM_PINS-1:0] & IMPL_MASK;
  assign unused_wdata = ^wdata_i[REG_W-1:NUM_PINS];
  assign wr_ctrl      = we_i && (addr_i == CTRL_ADDR);
  assign wr_dir       = we_i && (addr_i == DIR_ADDR);
  assign wr_data      = we_i && (addr_i == DATA_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      dir_q  <= '0;
    end else if (soft_rst_i) begin
      ctrl_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_val;
      if (wr_dir)  dir_q  <= wr_val;
    end
  end

  // data register intentionally has no reset
  always_ff @(posedge clk_i) begin
    if (wr_data) data_q <= wr_val;
  end

  always_comb begin
    unique case (addr_i)
      CTRL_ADDR: rdata_o = {{PAD_W{1'b0}}, ctrl_q};
      DIR_ADDR:  rdata_o = {{PAD_W{1'b0}}, dir_q};
      DATA_ADDR: rdata_o = {{PAD_W{1'b0}}, pin_rd_i & IMPL_MASK};
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign dir_o  = dir_q;
  assign data_o = data_q;
endmodule

// File: rtl/gpio_mux_pin.sv
module gpio_mux_pin
  import gpio_mux_pkg::*;
(
  input  logic ctrl_i,
  input  logic dir_i,
  input  logic data_i,
  input  logic pad_sync_i,
  input  logic pad_raw_i,
  input  logic per_out_i,
  input  logic per_oe_i,
  output logic pad_out_o,
  output logic pad_oe_o,
  output logic per_in_o,
  output logic rd_o
);
  pin_mode_e mode;
  assign mode = pin_mode_e'({dir_i, ctrl_i});

  always_comb begin
    pad_out_o = 1'b0;
    pad_oe_o  = 1'b0;
    per_in_o  = 1'b0;
    rd_o      = data_i;
    unique case (mode)
      PM_OFF: ;
      PM_IN:  rd_o = pad_sync_i;
      PM_OUT: begin
        pad_out_o = data_i;
        pad_oe_o  = 1'b1;
      end
      PM_PER: begin
        pad_out_o = per_out_i;
        pad_oe_o  = per_oe_i;
        per_in_o  = pad_raw_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int                  NUM_PINS    = 12,
  parameter int                  REG_W       = 24,
  parameter int                  ADDR_W      = 6,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0]   CTRL_ADDR   = 6'h1F,
  parameter logic [ADDR_W-1:0]   DIR_ADDR    = 6'h1E,
  parameter logic [ADDR_W-1:0]   DATA_ADDR   = 6'h1D,
  parameter logic [NUM_PINS-1:0] IMPL_MASK   = 12'hFDB
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  input  logic [NUM_PINS-1:0] per_out_i,
  input  logic [NUM_PINS-1:0] per_oe_i,
  output logic [NUM_PINS-1:0] per_in_o
);
  logic [NUM_PINS-1:0] ctrl_w, dir_w, data_w, pad_sync_w, pin_rd_w;

  gpio_mux_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pad_sync_w)
  );

  gpio_mux_regs #(
    .NUM_PINS(NUM_PINS), .REG_W(REG_W), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR),
    .IMPL_MASK(IMPL_MASK)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pin_rd_i  (pin_rd_w),
    .ctrl_o    (ctrl_w),
    .dir_o     (dir_w),
    .data_o    (data_w)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_mux_pin u_pin (
      .ctrl_i    (ctrl_w[i]),
      .dir_i     (dir_w[i]),
      .data_i    (data_w[i]),
      .pad_sync_i(pad_sync_w[i]),
      .pad_raw_i (pad_in_i[i]),
      .per_out_i (per_out_i[i]),
      .per_oe_i  (per_oe_i[i]),
      .pad_out_o (pad_out_o[i]),
      .pad_oe_o  (pad_oe_o[i]),
      .per_in_o  (per_in_o[i]),
      .rd_o      (pin_rd_w[i])
    );
  end
endmodule

// File: rtl/gpio_mux_chk.sv
module gpio_mux_chk #(
  parameter int                  NUM_PINS  = 12,
  parameter int                  REG_W     = 24,
  parameter int                  ADDR_W    = 6,
  parameter logic [ADDR_W-1:0]   CTRL_ADDR = 6'h1F,
  parameter logic [NUM_PINS-1:0] IMPL_MASK = 12'hFDB
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                soft_rst_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic [REG_W-1:0]    wdata_i,
  input logic [REG_W-1:0]    rdata_o,
  input logic [NUM_PINS-1:0] pad_in_i,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] per_out_i,
  input logic [NUM_PINS-1:0] per_oe_i,
  input logic [NUM_PINS-1:0] per_in_o,
  input logic [NUM_PINS-1:0] ctrl_w,
  input logic [NUM_PINS-1:0] dir_w
);
  assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[REG_W-1:NUM_PINS] == '0);

  assert_holes_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl_w | dir_w) & ~IMPL_MASK) == '0);

  assert_out_mode_oe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dir_w & ~ctrl_w) & ~pad_oe_o) == '0);

  assert_in_mode_no_oe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~dir_w & ctrl_w) & pad_oe_o) == '0);

  assert_per_route_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl_w & dir_w) & ((pad_out_o ^ per_out_i) | (pad_oe_o ^ per_oe_i) |
                         (per_in_o ^ pad_in_i))) == '0);

  assert_per_in_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~(ctrl_w & dir_w) & per_in_o) == '0);

  assert_off_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~ctrl_w & ~dir_w) & (pad_oe_o | pad_out_o)) == '0);

  assert_soft_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (ctrl_w == '0) && (dir_w == '0));

  assert_ctrl_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CTRL_ADDR && !soft_rst_i) |=>
      ctrl_w == ($past(wdata_i[NUM_PINS-1:0]) & IMPL_MASK));
endmodule

bind gpio_mux_port gpio_mux_chk #(
  .NUM_PINS(NUM_PINS), .REG_W(REG_W), .ADDR_W(ADDR_W),
  .CTRL_ADDR(CTRL_ADDR), .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
  .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
  .per_out_i(per_out_i), .per_oe_i(per_oe_i), .per_in_o(per_in_o),
  .ctrl_w(ctrl_w), .dir_w(dir_w)
);

// File: tb/tb_gpio_mux_port.sv
`timescale 1ns/1ps
module tb_gpio_mux_port;
  localparam int NP = 12;
  localparam int RW = 24;
  localparam logic [5:0] A_CTRL = 6'h1F, A_DIR = 6'h1E, A_DATA = 6'h1D;
  localparam logic [NP-1:0] MASK = 12'hFDB;

  logic clk_i = 1'b0, rst_ni = 1'b0, soft_rst_i = 1'b0, we_i = 1'b0;
  logic [5:0]    addr_i = '0;
  logic [RW-1:0] wdata_i = '0, rdata_o;
  logic [NP-1:0] pad_in_i = '0, pad_out_o, pad_oe_o, per_out_i = '0, per_oe_i = '0, per_in_o;

  int n_chk = 0, n_fail = 0;
  logic [NP-1:0] m_ctrl = '0, m_dir = '0, m_data = '0;

  always #2.5 clk_i = ~clk_i;

  gpio_mux_port dut (.*);

  task automatic chk(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [RW-1:0] d, input logic sr = 1'b0);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1; soft_rst_i = sr;
    @(negedge clk_i);
    we_i = 1'b0; soft_rst_i = 1'b0;
    if (sr) begin m_ctrl = '0; m_dir = '0; end
    else if (a == A_CTRL) m_ctrl = d[NP-1:0] & MASK;
    else if (a == A_DIR)  m_dir  = d[NP-1:0] & MASK;
    if (a == A_DATA) m_data = d[NP-1:0] & MASK;
  endtask

  function automatic logic [RW-1:0] exp_rd(input logic [5:0] a, input logic [NP-1:0] pin);
    logic [NP-1:0] v;
    case (a)
      A_CTRL: v = m_ctrl;
      A_DIR:  v = m_dir;
      A_DATA: v = ((~m_dir & m_ctrl) & pin) | (~(~m_dir & m_ctrl) & m_data);
      default: v = '0;
    endcase
    return {{(RW-NP){1'b0}}, v & MASK};
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    return (m_dir & ~m_ctrl) | (m_dir & m_ctrl & per_oe_i);
  endfunction
  function automatic logic [NP-1:0] exp_out();
    return (m_dir & ~m_ctrl & m_data) | (m_dir & m_ctrl & per_out_i);
  endfunction
  function automatic logic [NP-1:0] exp_pin();
    return m_dir & m_ctrl & pad_in_i;
  endfunction

  task automatic rd_chk(input string req, input logic [5:0] a);
    @(negedge clk_i);
    addr_i = a;
    #1 chk(req, rdata_o, exp_rd(a, pad_in_i));
  endtask

  task automatic check_all();
    rd_chk("R2 R3 R10 ctrl", A_CTRL);
    rd_chk("R2 R3 R10 dir", A_DIR);
    @(negedge clk_i);
    addr_i = A_DATA;
    #1;
    // disconnected pins are unspecified: compare the others only
    begin
      logic [RW-1:0] m;
      m = ~{{(RW-NP){1'b0}}, ~m_ctrl & ~m_dir & MASK};
      chk("R5 R6 data read", rdata_o & m, exp_rd(A_DATA, pad_in_i) & m);
    end
    chk("R4 R5 R7 pad_oe", RW'(pad_oe_o), RW'(exp_oe()));
    chk("R5 R7 R8 pad_out", RW'(pad_out_o), RW'(exp_out()));
    chk("R7 R8 per_in", RW'(per_in_o), RW'(exp_pin()));
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd_chk("R1 ctrl reset", A_CTRL);
    rd_chk("R1 dir reset", A_DIR);
    chk("R1 pad_oe reset", RW'(pad_oe_o), '0);

    // R2 R3 all ones
    wr(A_CTRL, 24'hFFFFFF); wr(A_DIR, 24'hFFFFFF); wr(A_DATA, 24'hFFFFFF);
    rd_chk("R2 R3 ctrl ones", A_CTRL);
    rd_chk("R2 R3 dir ones", A_DIR);
    rd_chk("R3 data ones", A_DATA);
    chk("R3 ctrl holes", {12'h0, rdata_o[11:0] & ~MASK}, '0);

    // R10 unmapped
    wr(6'h10, 24'hFFFFFF);
    rd_chk("R10 unmapped read", 6'h10);
    rd_chk("R10 unmapped no effect", A_CTRL);

    // R5 output mode
    wr(A_CTRL, 24'h0); wr(A_DIR, 24'h0FFF); wr(A_DATA, 24'h000A53);
    @(negedge clk_i); #1;
    chk("R5 pad_out", RW'(pad_out_o), RW'(12'hA53 & MASK));
    chk("R4 pad_oe out", RW'(pad_oe_o), RW'(MASK));

    // R6 input lag
    wr(A_DIR, 24'h0); wr(A_CTRL, 24'hFFF);
    @(negedge clk_i); pad_in_i = '0;
    repeat (3) @(negedge clk_i);
    addr_i = A_DATA; pad_in_i = 12'h001;
    @(negedge clk_i); #1 chk("R6 after 1 edge", rdata_o, '0);
    @(negedge clk_i); #1 chk("R6 after 2 edges", rdata_o, 24'h1);

    // R9 soft reset beats write, data kept
    wr(A_CTRL, 24'h0); wr(A_DIR, 24'h001); wr(A_DATA, 24'h001);
    wr(A_CTRL, 24'hFFF, 1'b1);
    rd_chk("R9 ctrl cleared", A_CTRL);
    rd_chk("R9 dir cleared", A_DIR);
    wr(A_DIR, 24'h001);
    @(negedge clk_i); #1 chk("R9 data kept", RW'(pad_out_o[0]), 24'h1);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [5:0] a;
      case ($urandom_range(0, 4))
        0: a = A_CTRL; 1: a = A_DIR; 2: a = A_DATA;
        3: a = 6'($urandom_range(0, 28)); default: a = A_CTRL;
      endcase
      wr(a, 24'($urandom), ($urandom_range(0, 15) == 0));
      @(negedge clk_i);
      pad_in_i = NP'($urandom); per_out_i = NP'($urandom); per_oe_i = NP'($urandom);
      repeat (2) @(negedge clk_i);
      check_all();
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule